// File: doc/BRIEF.md
# MIDI receive queue interrupt controller

This block sits between a serial MIDI byte receiver and the host-facing data and status ports of a MIDI host interface. Received bytes enter a small queue. A single holding register sits after the queue and shows exactly one byte at a time on the host data port. Whenever the holding register is filled, a level interrupt goes high. A host read of the data port takes the byte and drops the interrupt. If more bytes are queued, the next byte is moved up into the holding register one cycle later, and the interrupt rises again. Every received byte therefore produces its own interrupt edge. The interrupt does not wait for a fill threshold.

The byte stream enters through a valid/ready pair. The serial receiver cannot stall, so a byte is accepted in any cycle where `in_valid` and `in_ready` are both high. If `in_valid` is high while `in_ready` is low, the byte is discarded and a sticky overrun flag is raised. There is no back-pressure beyond this.

The receive-ready status and the interrupt follow the same rules in every host-side operating mode, so a single instance serves both pass-through and command-processing use.

Top module: `midi_rx_irq_ctrl`

## Requirements
- R1: When a byte is accepted into an otherwise empty block, `irq` stays low after the accepting edge and is high after the next rising edge. It does not wait for the queue to fill.
- R2: A pulse on `rd_data_stb` while `irq` is high empties the holding register, and `irq` is low after that edge.
- R3: If bytes remain queued after such a read, the next byte is promoted at the following edge and `irq` is high again after it. `irq` is low for exactly one sampled cycle per read.
- R4: `rx_ready` is high whenever the holding register or the queue holds a byte. This includes the cycle in which `irq` is low between two bytes.
- R5: Bytes reach `host_data` in arrival order. The block holds DEPTH+1 bytes (queue plus holding register). `in_ready` is low exactly when the queue holds DEPTH bytes.
- R6: A byte offered with `in_valid` high while `in_ready` is low is dropped, and `overrun` is set. A pulse on `rd_stat_stb` clears `overrun`. If a drop and a clear happen in the same cycle, the set wins.
- R7: A `rd_data_stb` pulse while `rx_ready` is low leaves `host_data` unchanged and leaves `irq` low.
- R8: A synchronous `rst` empties the queue and the holding register, lowers `irq` and `overrun`, and leaves `host_data` at 0.
- R9: If a byte arrives in the same cycle as a read that empties the holding register, `irq` is low after that edge. The new byte is in the holding register, with `irq` high, after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Received byte valid |
| in_ready | output | 1 | Queue has room; low means an offered byte is dropped |
| in_data | input | DATA_W | Received byte |
| rd_data_stb | input | 1 | One-cycle host read of the data port |
| rd_stat_stb | input | 1 | One-cycle host read of the status port |
| host_data | output | DATA_W | Holding register contents (last byte presented) |
| rx_ready | output | 1 | At least one byte is available |
| irq | output | 1 | Level interrupt request |
| overrun | output | 1 | Sticky flag: a byte was dropped |

## Verification
The properties assume that `rd_data_stb` and `rd_stat_stb` are single-cycle pulses, synchronous to `clk`. They also assume that `rst` is high from time zero, so that `$past` never looks at values from before reset. The bench drives every input one time unit after a rising edge and holds it for one whole cycle, so each strobe is seen at exactly one edge. The bench sweeps burst lengths from one byte to three past capacity, then drains each burst one read at a time. It adds directed cases for the read-while-empty case, the read-with-same-cycle-arrival case, and a mid-stream reset.

// File: rtl/midi_rxq_pkg.sv
package midi_rxq_pkg;
  localparam int MIDI_W = 8;
  localparam int DEFAULT_DEPTH = 16;
endpackage

// File: rtl/midi_rxq_fifo.sv
module midi_rxq_fifo #(
  parameter int DEPTH  = midi_rxq_pkg::DEFAULT_DEPTH,
  parameter int DATA_W = midi_rxq_pkg::MIDI_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              empty,
  output logic              full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP  = CW'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count;
  logic              do_push, do_pop;

  assign empty   = (count == '0);
  assign full    = (count == CAP);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/midi_rxq_hold.sv
module midi_rxq_hold #(
  parameter int DATA_W = midi_rxq_pkg::MIDI_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_stb,
  input  logic              q_empty,
  input  logic [DATA_W-1:0] q_head,
  output logic              pop,
  output logic              hold_valid,
  output logic [DATA_W-1:0] hold_data,
  output logic              irq
);
  // Promote only into an empty holding register; the read edge empties it,
  // so promotion lands one edge later and leaves one low irq cycle.
  assign pop = !hold_valid && !q_empty;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_valid <= 1'b0;
      hold_data  <= '0;
      irq        <= 1'b0;
    end else if (pop) begin
      hold_valid <= 1'b1;
      hold_data  <= q_head;
      irq        <= 1'b1;
    end else if (rd_stb && hold_valid) begin
      hold_valid <= 1'b0;
      irq        <= 1'b0;
    end
  end
endmodule

// File: rtl/midi_rxq_ovr.sv
module midi_rxq_ovr (
  input  logic clk,
  input  logic rst,
  input  logic drop,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)       flag <= 1'b0;
    else if (drop) flag <= 1'b1;
    else if (clr)  flag <= 1'b0;
  end
endmodule

// File: rtl/midi_rx_irq_ctrl.sv
module midi_rx_irq_ctrl #(
  parameter int DEPTH  = midi_rxq_pkg::DEFAULT_DEPTH,
  parameter int DATA_W = midi_rxq_pkg::MIDI_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              rd_data_stb,
  input  logic              rd_stat_stb,
  output logic [DATA_W-1:0] host_data,
  output logic              rx_ready,
  output logic              irq,
  output logic              overrun
);
  logic              q_empty, q_full, q_pop, hold_valid;
  logic [DATA_W-1:0] q_head;

  assign in_ready = !q_full;
  assign rx_ready = hold_valid || !q_empty;

  midi_rxq_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
    .clk(clk), .rst(rst),
    .push(in_valid), .push_data(in_data),
    .pop(q_pop), .head(q_head),
    .empty(q_empty), .full(q_full)
  );

  midi_rxq_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst(rst), .rd_stb(rd_data_stb),
    .q_empty(q_empty), .q_head(q_head),
    .pop(q_pop), .hold_valid(hold_valid),
    .hold_data(host_data), .irq(irq)
  );

  midi_rxq_ovr u_ovr (
    .clk(clk), .rst(rst),
    .drop(in_valid && q_full), .clr(rd_stat_stb),
    .flag(overrun)
  );
endmodule

// File: rtl/midi_rxq_chk.sv
module midi_rxq_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              rd_data_stb,
  input logic [DATA_W-1:0] host_data,
  input logic              rx_ready,
  input logic              irq,
  input logic              overrun
);
  // R1
  first_byte_irq_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && in_ready && !rx_ready |=> ##1 irq);
  // R2
  read_drops_irq_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data_stb && irq |=> !irq);
  // R3
  requeue_irq_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rd_data_stb && irq) && rx_ready |=> irq);
  // R4
  irq_implies_ready_chk: assert property (@(posedge clk) disable iff (rst)
    irq |-> rx_ready);
  // R6
  drop_sets_ovr_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid && !in_ready |=> overrun);
  // R7
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    rd_data_stb && !rx_ready |=> $stable(host_data) && !irq);
endmodule

bind midi_rx_irq_ctrl midi_rxq_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .rd_data_stb(rd_data_stb), .host_data(host_data), .rx_ready(rx_ready),
  .irq(irq), .overrun(overrun)
);

// File: tb/midi_rx_irq_ctrl_tb_top.sv
module midi_rx_irq_ctrl_tb_top;
  localparam int DEPTH = 16;
  localparam int DW = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst = 1'b1, in_valid = 1'b0, rd_data_stb = 1'b0, rd_stat_stb = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, rx_ready, irq, overrun;
  logic [DW-1:0] host_data;
  int checks = 0, errors = 0;

  midi_rx_irq_ctrl #(.DEPTH(DEPTH), .DATA_W(DW)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .rd_data_stb(rd_data_stb), .rd_stat_stb(rd_stat_stb),
    .host_data(host_data), .rx_ready(rx_ready), .irq(irq), .overrun(overrun)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    #1;
  endtask

  function automatic int val(input int n, input int i);
    return (n * 37 + i * 11 + 3) & 255;
  endfunction

  initial begin
    tick; tick; rst = 1'b0;
    // R8 reset state
    chk(irq == 0, "R8 irq", irq, 0);
    chk(rx_ready == 0, "R8 rx_ready", rx_ready, 0);
    chk(overrun == 0, "R8 overrun", overrun, 0);
    chk(host_data == 0, "R8 host_data", host_data, 0);
    chk(in_ready == 1, "R5 in_ready idle", in_ready, 1);

    for (int n = 1; n <= DEPTH + 3; n++) begin
      int kept;
      bit exp_ovr;
      logic [DW-1:0] last;
      kept = (n < DEPTH + 1) ? n : DEPTH + 1;
      exp_ovr = (n > DEPTH + 1);
      for (int i = 0; i < n; i++) begin
        in_valid = 1'b1;
        in_data = DW'(val(n, i));
        tick;
        if (n == 1) begin
          chk(irq == 0, "R1 irq after accept edge", irq, 0);
          chk(rx_ready == 1, "R4 ready before promotion", rx_ready, 1);
        end
      end
      in_valid = 1'b0;
      tick;
      if (n == 1) chk(irq == 1, "R1 irq one edge later", irq, 1);
      tick;
      chk(overrun == exp_ovr, "R6 overrun after burst", overrun, exp_ovr);
      chk(in_ready == (kept - 1 < DEPTH), "R5 in_ready vs fill", in_ready, kept - 1 < DEPTH);
      for (int i = 0; i < kept; i++) begin
        chk(irq == 1, "R3 irq before read", irq, 1);
        chk(host_data == DW'(val(n, i)), "R5 order", host_data, val(n, i));
        rd_data_stb = 1'b1;
        tick;
        rd_data_stb = 1'b0;
        chk(irq == 0, "R2 irq low after read", irq, 0);
        chk(rx_ready == (i < kept - 1), "R4 ready during gap", rx_ready, i < kept - 1);
        tick;
        chk(irq == (i < kept - 1), "R3 irq re-asserts", irq, i < kept - 1);
      end
      last = host_data;
      rd_data_stb = 1'b1;
      tick;
      rd_data_stb = 1'b0;
      tick;
      chk(host_data == last, "R7 data kept", host_data, last);
      chk(irq == 0, "R7 no irq", irq, 0);
      chk(rx_ready == 0, "R7 queue unchanged", rx_ready, 0);
      rd_stat_stb = 1'b1;
      tick;
      rd_stat_stb = 1'b0;
      chk(overrun == 0, "R6 overrun cleared", overrun, 0);
    end

    // R9 same-cycle arrival with emptying read
    in_valid = 1'b1; in_data = 8'hA5; tick;
    in_valid = 1'b0; tick; tick;
    chk(irq == 1, "R9 setup irq", irq, 1);
    rd_data_stb = 1'b1; in_valid = 1'b1; in_data = 8'h3C; tick;
    rd_data_stb = 1'b0; in_valid = 1'b0;
    chk(irq == 0, "R9 irq low", irq, 0);
    chk(host_data == 8'hA5, "R9 old data", host_data, 8'hA5);
    chk(rx_ready == 1, "R9 ready", rx_ready, 1);
    tick;
    chk(irq == 1, "R9 irq back", irq, 1);
    chk(host_data == 8'h3C, "R9 new data", host_data, 8'h3C);
    rd_data_stb = 1'b1; tick; rd_data_stb = 1'b0; tick;

    // R8 mid-stream reset
    for (int i = 0; i < 3; i++) begin
      in_valid = 1'b1; in_data = DW'(i + 1); tick;
    end
    in_valid = 1'b0;
    rst = 1'b1; tick; rst = 1'b0;
    chk(irq == 0, "R8 irq after reset", irq, 0);
    chk(rx_ready == 0, "R8 empty after reset", rx_ready, 0);
    chk(host_data == 0, "R8 data after reset", host_data, 0);
    in_valid = 1'b1; in_data = 8'h77; tick;
    in_valid = 1'b0; tick;
    chk(host_data == 8'h77, "R8 fresh byte first", host_data, 8'h77);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule